// File: doc/BRIEF.md
# Relocatable Standby SRAM Controller

This block holds a small word-wide SRAM array that software can place anywhere in a 24-bit address space. Four 16-bit registers control it. A control register holds a power-down bit, a sticky lock and a two-bit access-class field. A test register is present but does nothing. Two base registers give the array's position. Each memory-space request is compared against the programmed base. On a match the block either performs the access or refuses it with an error response.

Refusal covers two cases. While the power-down bit is set, the array keeps its contents but nothing is read from it or written to it. The array can also be restricted to program fetches, and then data requests are refused. Once the lock is set, only reset clears it, and it freezes the base registers so the array cannot be relocated by accident.

A request is presented for one cycle. The response (ready, error and read data) appears in the following cycle. Requests that miss the array get no ready, so another responder can claim them.

Top module: `reloc_sram`

## Requirements
- R1: After reset the control register reads 0x8300 (power-down bit 15 set, class field bits 9:8 = 11, lock bit 11 clear), and the test, base-high and base-low registers read 0x0000.
- R2: Register select uses addr_i[2:1]: 0 = control, 1 = test, 2 = base high, 3 = base low. In the control register only bits 15, 11, 9 and 8 are stored, and every other bit reads as zero.
- R3: Writing 1 to control bit 11 sets the lock. Later writes of 0 leave it set, and only reset clears it.
- R4: While the lock is set, writes to both base registers are ignored: their readback does not change and the array stays where it was.
- R5: Base high holds address bits 23:16 in its bits 7:0. Base low holds address bits 15:10 in its bits 15:10. All other base bits read as zero.
- R6: A memory-space request gets no ready unless a base-low write has occurred since reset and addr_i[23:10] equals the programmed base. Requests that miss get no ready either.
- R7: A matching request that is allowed completes: a write stores wdata_i at the word addr_i[9:1], and a read returns that word, in both cases with err_o low.
- R8: While the power-down bit is set, every matching request returns rdata_o = 0 with err_o high and stores nothing. Contents written earlier read back unchanged after the bit is cleared.
- R9: With class bit 8 = 1, data requests (prog_i = 0) are refused with err_o high and rdata_o = 0, and program requests are served. With bit 8 = 0, both kinds are served.
- R10: Class bit 9 is stored and read back but has no effect on whether a request is served.
- R11: Register requests and matching memory requests see ready_o high exactly in the cycle after the request. The test register reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid for one cycle |
| is_reg_i | input | 1 | 1 = register block access, 0 = memory space access |
| we_i | input | 1 | Write enable |
| prog_i | input | 1 | 1 = program fetch, 0 = data access |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Response valid, one cycle after the request |
| err_o | output | 1 | Refused access (power-down or class violation) |
| rdata_o | output | 16 | Read data, zero on writes and errors |

## Verification
The bench builds the block with its default parameters: a 24-bit bus and a 1 KB array of 512 sixteen-bit words. With the base tag 14 bits wide, a one-bit change in the tag produces a miss right next to a hit, so near-miss addresses are easy to generate. Because the array is this small, random traffic reuses the same words many times. That reuse brings read-after-write, refused writes that must leave old data in place, and data surviving power-down within reach in a few hundred requests.

// File: rtl/reloc_sram_pkg.sv
package reloc_sram_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_TEST    = 2'd1,
    SEL_BASE_HI = 2'd2,
    SEL_BASE_LO = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_REG  = 2'd1,
    RSP_ARR  = 2'd2
  } rsp_kind_e;

  localparam int unsigned CTRL_PDN_BIT  = 15;
  localparam int unsigned CTRL_LOCK_BIT = 11;
  localparam int unsigned CTRL_CLS_LSB  = 8;

  typedef struct packed {
    logic       pdn;
    logic       lock;
    logic [1:0] cls;
  } ctrl_t;
endpackage

// File: rtl/reloc_sram_regs.sv
module reloc_sram_regs
  import reloc_sram_pkg::*;
#(
  parameter int unsigned BUS_AW   = 24,
  parameter int unsigned ARRAY_AW = 10,
  localparam int unsigned TAG_W   = BUS_AW - ARRAY_AW,
  localparam int unsigned HI_W    = BUS_AW - 16,
  localparam int unsigned LO_W    = 16 - ARRAY_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_sel_e         sel_i,
  input  logic [15:0]      wdata_i,
  output ctrl_t            ctrl_o,
  output logic [TAG_W-1:0] base_o,
  output logic             base_vld_o,
  output logic [15:0]      rdata_o
);
  ctrl_t            ctrl_q;
  logic [TAG_W-1:0] base_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{pdn: 1'b1, lock: 1'b0, cls: 2'b11};
      base_q <= '0;
      vld_q  <= 1'b0;
    end else if (wr_i) begin
      unique case (sel_i)
        SEL_CTRL: begin
          ctrl_q.pdn  <= wdata_i[CTRL_PDN_BIT];
          ctrl_q.lock <= ctrl_q.lock | wdata_i[CTRL_LOCK_BIT];
          ctrl_q.cls  <= wdata_i[CTRL_CLS_LSB +: 2];
        end
        SEL_BASE_HI: if (!ctrl_q.lock) base_q[TAG_W-1 -: HI_W] <= wdata_i[HI_W-1:0];
        SEL_BASE_LO: if (!ctrl_q.lock) begin
          base_q[LO_W-1:0] <= wdata_i[15:ARRAY_AW];
          vld_q            <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL: begin
        rdata_o[CTRL_PDN_BIT]       = ctrl_q.pdn;
        rdata_o[CTRL_LOCK_BIT]      = ctrl_q.lock;
        rdata_o[CTRL_CLS_LSB +: 2]  = ctrl_q.cls;
      end
      SEL_BASE_HI: rdata_o[HI_W-1:0]     = base_q[TAG_W-1 -: HI_W];
      SEL_BASE_LO: rdata_o[15:ARRAY_AW]  = base_q[LO_W-1:0];
      default:     rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign base_o     = base_q;
  assign base_vld_o = vld_q;
endmodule

// File: rtl/reloc_sram_decode.sv
module reloc_sram_decode
  import reloc_sram_pkg::*;
#(
  parameter int unsigned TAG_W = 14
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] base_i,
  input  logic             base_vld_i,
  input  ctrl_t            ctrl_i,
  input  logic             prog_i,
  output logic             hit_o,
  output logic             deny_o
);
  assign hit_o  = base_vld_i && (tag_i == base_i);
  // cls[1] intentionally unused: single privilege level
  assign deny_o = ctrl_i.pdn || (ctrl_i.cls[0] && !prog_i);
endmodule

// File: rtl/reloc_sram_array.sv
module reloc_sram_array #(
  parameter int unsigned WORDS  = 512,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[idx_i] <= wdata_i;
      else      rdata_o      <= mem_q[idx_i];
    end
  end
endmodule

// File: rtl/reloc_sram.sv
module reloc_sram
  import reloc_sram_pkg::*;
#(
  parameter int unsigned BUS_AW   = 24,
  parameter int unsigned ARRAY_AW = 10,
  localparam int unsigned TAG_W   = BUS_AW - ARRAY_AW,
  localparam int unsigned WORDS   = 2 ** (ARRAY_AW - 1),
  localparam int unsigned IDX_W   = ARRAY_AW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              is_reg_i,
  input  logic              we_i,
  input  logic              prog_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic              ready_o,
  output logic              err_o,
  output logic [15:0]       rdata_o
);
  ctrl_t            ctrl;
  logic [TAG_W-1:0] base;
  logic             base_vld;
  logic [15:0]      reg_rdata;
  logic [15:0]      arr_rdata;
  logic             hit, deny;
  logic             lock_st, pdn_st;

  logic      arr_sel, arr_go, reg_wr;
  reg_sel_e  sel;

  logic        ready_q, err_q;
  rsp_kind_e   kind_q;
  logic [15:0] reg_q;

  assign sel     = reg_sel_e'(addr_i[2:1]);
  assign reg_wr  = req_i && is_reg_i && we_i;
  assign arr_sel = req_i && !is_reg_i && hit;
  assign arr_go  = arr_sel && !deny;
  assign lock_st = ctrl.lock;
  assign pdn_st  = ctrl.pdn;

  reloc_sram_regs #(.BUS_AW(BUS_AW), .ARRAY_AW(ARRAY_AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl),
    .base_o     (base),
    .base_vld_o (base_vld),
    .rdata_o    (reg_rdata)
  );

  reloc_sram_decode #(.TAG_W(TAG_W)) u_dec (
    .tag_i      (addr_i[BUS_AW-1:ARRAY_AW]),
    .base_i     (base),
    .base_vld_i (base_vld),
    .ctrl_i     (ctrl),
    .prog_i     (prog_i),
    .hit_o      (hit),
    .deny_o     (deny)
  );

  reloc_sram_array #(.WORDS(WORDS), .DATA_W(16)) u_arr (
    .clk_i   (clk_i),
    .en_i    (arr_go),
    .we_i    (we_i),
    .idx_i   (addr_i[ARRAY_AW-1:1]),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      kind_q  <= RSP_NONE;
      reg_q   <= '0;
    end else begin
      ready_q <= req_i && (is_reg_i || hit);
      err_q   <= arr_sel && deny;
      reg_q   <= reg_rdata;
      if (req_i && is_reg_i && !we_i)      kind_q <= RSP_REG;
      else if (arr_go && !we_i)            kind_q <= RSP_ARR;
      else                                 kind_q <= RSP_NONE;
    end
  end

  always_comb begin
    unique case (kind_q)
      RSP_REG: rdata_o = reg_q;
      RSP_ARR: rdata_o = arr_rdata;
      default: rdata_o = '0;
    endcase
  end

  assign ready_o = ready_q;
  assign err_o   = err_q;
endmodule

// File: rtl/reloc_sram_chk.sv
module reloc_sram_chk #(
  parameter int unsigned TAG_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             is_reg_i,
  input logic             ready_o,
  input logic             err_o,
  input logic [15:0]      rdata_o,
  input logic             lock_i,
  input logic             pdn_i,
  input logic             hit_i,
  input logic             base_vld_i,
  input logic [TAG_W-1:0] base_i
);
  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_i) |-> lock_i);

  assert_base_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_i) |-> $stable(base_i));

  assert_no_rsp_unmapped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_reg_i && !base_vld_i) |=> !ready_o);

  assert_pdn_refuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_reg_i && hit_i && pdn_i) |=> (err_o && rdata_o == 16'h0));

  assert_err_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ready_o && rdata_o == 16'h0));

  assert_ready_after_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(req_i));

  assert_reg_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_reg_i) |=> ready_o);
endmodule

bind reloc_sram reloc_sram_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .is_reg_i   (is_reg_i),
  .ready_o    (ready_o),
  .err_o      (err_o),
  .rdata_o    (rdata_o),
  .lock_i     (lock_st),
  .pdn_i      (pdn_st),
  .hit_i      (hit),
  .base_vld_i (base_vld),
  .base_i     (base)
);

// File: tb/reloc_sram_tb_top.sv
module reloc_sram_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, is_reg_i = 1'b0, we_i = 1'b0, prog_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ready_o, err_o;
  logic [15:0] rdata_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  logic [15:0] mdl [512];
  bit          mvld [512];
  logic        m_pdn, m_lock;
  logic [1:0]  m_cls;
  logic [13:0] m_tag;

  always #2.5 clk_i = ~clk_i;

  reloc_sram dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .is_reg_i(is_reg_i),
    .we_i(we_i), .prog_i(prog_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ready_o(ready_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  function automatic logic [15:0] ctrl_word(logic pdn, logic lock, logic [1:0] cls);
    return {pdn, 3'b000, lock, 1'b0, cls, 8'h00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic r, input logic w, input logic [23:0] a, input logic [15:0] d,
                      input logic p, output logic rdy, output logic er, output logic [15:0] rd);
    @(negedge clk_i);
    req_i = 1'b1; is_reg_i = r; we_i = w; addr_i = a; wdata_i = d; prog_i = p;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    rdy = ready_o; er = err_o; rd = rdata_o;
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [15:0] d, input string req);
    logic rdy, er; logic [15:0] rd;
    xfer(1'b1, 1'b1, {21'h0, s, 1'b0}, d, 1'b0, rdy, er, rd);
    chk(rdy === 1'b1, req, {31'h0, rdy}, 32'h1);
  endtask

  task automatic reg_rd(input logic [1:0] s, input logic [15:0] exp, input string req);
    logic rdy, er; logic [15:0] rd;
    xfer(1'b1, 1'b0, {21'h0, s, 1'b0}, 16'h0, 1'b0, rdy, er, rd);
    chk(rdy === 1'b1 && rd === exp, req, {15'h0, rdy, rd}, {15'h0, 1'b1, exp});
  endtask

  // memory access with full expected-response computation
  task automatic mem_op(input logic w, input logic [23:0] a, input logic [15:0] d, input logic p, input string req);
    logic rdy, er; logic [15:0] rd;
    bit hitx, deny;
    int unsigned ix;
    hitx = (a[23:10] == m_tag);
    deny = m_pdn || (m_cls[0] && !p);
    ix   = a[9:1];
    xfer(1'b0, w, a, d, p, rdy, er, rd);
    if (!hitx) begin
      chk(rdy === 1'b0, req, {31'h0, rdy}, 32'h0);
    end else if (deny) begin
      chk(rdy === 1'b1 && er === 1'b1 && rd === 16'h0, req, {14'h0, rdy, er, rd}, {14'h0, 2'b11, 16'h0});
    end else begin
      if (w) begin
        mdl[ix] = d; mvld[ix] = 1'b1;
        chk(rdy === 1'b1 && er === 1'b0, req, {14'h0, rdy, er, rd}, {14'h0, 2'b10, 16'h0});
      end else if (mvld[ix]) begin
        chk(rdy === 1'b1 && er === 1'b0 && rd === mdl[ix], req, {14'h0, rdy, er, rd}, {14'h0, 2'b10, mdl[ix]});
      end else begin
        chk(rdy === 1'b1 && er === 1'b0, req, {31'h0, rdy}, 32'h1);
      end
    end
  endtask

  task automatic set_ctrl(input logic pdn, input logic lk, input logic [1:0] cls, input string req);
    reg_wr(2'd0, ctrl_word(pdn, lk, cls), req);
    m_pdn = pdn; m_lock = m_lock | lk; m_cls = cls;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic rdy, er; logic [15:0] rd;
    logic [23:0] base_addr;
    void'($urandom(32'h1a2b3c4d));
    for (int i = 0; i < 512; i++) mvld[i] = 1'b0;
    m_pdn = 1'b1; m_lock = 1'b0; m_cls = 2'b11; m_tag = '1;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values
    reg_rd(2'd0, 16'h8300, "R1 ctrl reset");
    reg_rd(2'd1, 16'h0000, "R1 test reset");
    reg_rd(2'd2, 16'h0000, "R1 base_hi reset");
    reg_rd(2'd3, 16'h0000, "R1 base_lo reset");

    // R6 no response before base-low written (base tag 0 would otherwise match)
    xfer(1'b0, 1'b0, 24'h000010, 16'h0, 1'b1, rdy, er, rd);
    chk(rdy === 1'b0, "R6 unmapped before base", {31'h0, rdy}, 32'h0);
    reg_wr(2'd2, 16'h0034, "R6 base_hi only");
    xfer(1'b0, 1'b0, 24'h340010, 16'h0, 1'b1, rdy, er, rd);
    chk(rdy === 1'b0, "R6 base_hi alone does not map", {31'h0, rdy}, 32'h0);

    // R2 stored bits only
    reg_wr(2'd0, 16'h76FF, "R2 ctrl write");
    reg_rd(2'd0, 16'h0200, "R2 ctrl mask a");
    reg_wr(2'd0, 16'hF4FF, "R2 ctrl write");
    reg_rd(2'd0, 16'h8000, "R2 ctrl mask b");

    // R5 base field layout
    reg_wr(2'd2, 16'hAB12, "R5 base_hi write");
    reg_rd(2'd2, 16'h0012, "R5 base_hi readback");
    reg_wr(2'd3, 16'hFFFF, "R5 base_lo write");
    reg_rd(2'd3, 16'hFC00, "R5 base_lo readback");
    m_tag = 14'h12FC >> 2 | 14'h0; m_tag = {8'h12, 6'h3F};
    base_addr = {m_tag, 10'h0};

    // R7 basic hit
    set_ctrl(1'b0, 1'b0, 2'b00, "R7 ctrl");
    mem_op(1'b1, base_addr + 24'h10, 16'h1234, 1'b0, "R7 write");
    mem_op(1'b0, base_addr + 24'h10, 16'h0, 1'b0, "R7 read");
    mem_op(1'b0, base_addr + 24'h11, 16'h0, 1'b1, "R7 odd byte same word");
    // R6 near miss
    mem_op(1'b0, base_addr ^ 24'h000400, 16'h0, 1'b0, "R6 near miss");
    mem_op(1'b0, base_addr ^ 24'h800000, 16'h0, 1'b0, "R6 far miss");

    // R8 power-down keeps data, refuses access
    mem_op(1'b1, base_addr + 24'h3FE, 16'hBEEF, 1'b0, "R8 pre write");
    set_ctrl(1'b1, 1'b0, 2'b00, "R8 pdn on");
    mem_op(1'b0, base_addr + 24'h3FE, 16'h0, 1'b1, "R8 read refused");
    mem_op(1'b1, base_addr + 24'h3FE, 16'h5555, 1'b1, "R8 write refused");
    set_ctrl(1'b0, 1'b0, 2'b00, "R8 pdn off");
    mem_op(1'b0, base_addr + 24'h3FE, 16'h0, 1'b0, "R8 contents kept");

    // R9 program-only
    set_ctrl(1'b0, 1'b0, 2'b01, "R9 ctrl");
    mem_op(1'b0, base_addr + 24'h10, 16'h0, 1'b0, "R9 data read refused");
    mem_op(1'b1, base_addr + 24'h10, 16'h7777, 1'b0, "R9 data write refused");
    mem_op(1'b0, base_addr + 24'h10, 16'h0, 1'b1, "R9 program read served");

    // R10 high class bit inert
    set_ctrl(1'b0, 1'b0, 2'b10, "R10 ctrl");
    reg_rd(2'd0, 16'h0200, "R10 readback");
    mem_op(1'b0, base_addr + 24'h10, 16'h0, 1'b0, "R10 data served");

    // R11 test register inert
    reg_wr(2'd1, 16'hFFFF, "R11 test write");
    reg_rd(2'd1, 16'h0000, "R11 test reads zero");

    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [23:0] a;
      if (k % 8 == 0)
        set_ctrl(($urandom % 4) == 0, 1'b0, 2'($urandom), "R9 random ctrl");
      a = {m_tag, 9'($urandom), 1'($urandom)};
      if (($urandom % 8) == 0) a[23:10] = m_tag ^ 14'(1 << ($urandom % 14));
      mem_op(1'($urandom), a, 16'($urandom), 1'($urandom), "R7 random");
    end

    // R3/R4 lock
    set_ctrl(1'b0, 1'b1, 2'b00, "R3 lock set");
    reg_rd(2'd0, 16'h0800, "R3 lock reads");
    reg_wr(2'd2, 16'h0055, "R4 base_hi locked");
    reg_wr(2'd3, 16'h0400, "R4 base_lo locked");
    reg_rd(2'd2, 16'h0012, "R4 base_hi unchanged");
    reg_rd(2'd3, 16'hFC00, "R4 base_lo unchanged");
    mem_op(1'b1, base_addr + 24'h20, 16'hA5A5, 1'b0, "R4 array not moved");
    mem_op(1'b0, base_addr + 24'h20, 16'h0, 1'b0, "R4 array not moved");
    xfer(1'b0, 1'b0, 24'h550420, 16'h0, 1'b0, rdy, er, rd);
    chk(rdy === 1'b0, "R4 new base not mapped", {31'h0, rdy}, 32'h0);
    set_ctrl(1'b0, 1'b0, 2'b00, "R3 clear attempt");
    reg_rd(2'd0, 16'h0800, "R3 lock sticky");

    // reset clears lock
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    reg_rd(2'd0, 16'h8300, "R3 reset clears lock");
    reg_rd(2'd3, 16'h0000, "R1 base after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule